// File: doc/BRIEF.md
# PLL Reference Prescaler Unit

This block picks the reference for a group of three PLLs and divides it down separately for each one. The reference choice is one of three oscillator tick streams, or nothing at all. All logic runs on one system clock. Each oscillator arrives as a one-cycle tick qualifier in that clock domain. Each prescaler counts the ticks of the chosen source and emits a one-cycle enable pulse on its output once per programmed ratio.

Software programs the block through a single write strobe with a data word that holds the source field and one 6-bit divide field per prescaler. The block write-protects the configuration against changes while PLLs run. The source field changes only when every PLL enable input is low. A prescaler's divide field changes only while that prescaler's own PLL enable is low. A read port always shows the held configuration, so software can tell whether a write took effect.

Top module: `refpre_unit`

## Requirements
- R1: Source code 0 routes `osc_tick[0]`, code 1 routes `osc_tick[1]` and code 2 routes `osc_tick[2]` to all prescalers. Ticks on the sources that are not selected have no effect on `ref_en`.
- R2: After reset the source field is 0, prescalers 0 and 1 hold divide code 32, prescaler 2 holds divide code 0, and `ref_en` is all low while no tick arrives.
- R3: A write leaves the source field unchanged whenever any bit of `pll_on` is high.
- R4: Divide code 0 keeps that `ref_en` bit low. Divide code 1 makes that `ref_en` bit equal to the selected tick of the previous cycle.
- R5: A write leaves divide field k unchanged while `pll_on[k]` is high. Fields of the same write whose protection is clear still update.
- R6: With divide code N from 2 to 63, the output pulses once every N selected ticks and is never high in two successive cycles.
- R7: An accepted write of a divide field restarts that prescaler. It pulses on the first selected tick after the write edge and then every N ticks.
- R8: `rd_data` and `wr_data` share one layout. The source field is at bits [1:0] and the divide field of prescaler k is at bits [2+6k +: 6].
- R9: Source code 3 keeps every `ref_en` bit low, whatever the oscillator ticks do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 20 | Write word: source and three divide fields |
| pll_on | input | 3 | Per-PLL enable, write protection |
| osc_tick | input | 3 | Tick qualifiers of the three oscillators |
| rd_data | output | 20 | Current configuration word |
| ref_en | output | 3 | Divided reference enable pulse per PLL |

## Verification
A protection rule that is missing or too broad shows on `rd_data` in the cycle after the blocked or accepted write, because the read port returns the held fields directly. A counter that reloads with the wrong value or misses a restart appears as a wrong gap between `ref_en` pulses. The gap is measured from the pulse one cycle after the write. A wrong source decode appears within two cycles as pulses that follow an oscillator that was not selected, or as no pulses at all.

// File: rtl/refpre_pkg.sv
package refpre_pkg;

    localparam int NUM_PLL     = 3;
    localparam int DIV_W       = 6;
    localparam int SRC_W       = 2;
    localparam int NUM_SRC     = 3;
    localparam int CFG_W       = SRC_W + NUM_PLL * DIV_W;
    localparam int DIV_RESET_A = 32;
    localparam int NUM_RESET_A = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_OSC_A   = 2'd0,
        SRC_OSC_B   = 2'd1,
        SRC_OSC_EXT = 2'd2,
        SRC_NONE    = 2'd3
    } src_sel_e;

    typedef logic [DIV_W-1:0] div_code_t;

    typedef struct packed {
        div_code_t [NUM_PLL-1:0] div;
        src_sel_e                src;
    } cfg_t;

    typedef enum logic [1:0] {
        DIV_OFF,
        DIV_PASS,
        DIV_COUNT
    } div_mode_e;

    function automatic div_mode_e decode_div(input div_code_t code);
        if (code == '0)
            return DIV_OFF;
        else if (code == div_code_t'(1))
            return DIV_PASS;
        else
            return DIV_COUNT;
    endfunction

    function automatic div_code_t reset_div(input int idx);
        return (idx < NUM_RESET_A) ? div_code_t'(DIV_RESET_A) : '0;
    endfunction

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.src = SRC_OSC_A;
        for (int k = 0; k < NUM_PLL; k++)
            c.div[k] = reset_div(k);
        return c;
    endfunction

endpackage

// File: rtl/refpre_cfg.sv
module refpre_cfg
    import refpre_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  cfg_t               wr_cfg,
    input  logic [NUM_PLL-1:0] pll_on,
    output cfg_t               cfg_q,
    output logic [NUM_PLL-1:0] restart
);

    logic src_open;

    assign src_open = (pll_on == '0);

    always_comb begin
        for (int k = 0; k < NUM_PLL; k++)
            restart[k] = wr_en && !pll_on[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_reset();
        end else if (wr_en) begin
            if (src_open)
                cfg_q.src <= wr_cfg.src;
            for (int k = 0; k < NUM_PLL; k++) begin
                if (!pll_on[k])
                    cfg_q.div[k] <= wr_cfg.div[k];
            end
        end
    end

    // R3: source field frozen while any PLL runs
    a_r3_src_hold: assert property (@(posedge clk) disable iff (rst)
        (pll_on != '0) |=> (cfg_q.src == $past(cfg_q.src)));

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_hold
        // R5: divide field frozen while its own PLL runs
        a_r5_div_hold: assert property (@(posedge clk) disable iff (rst)
            pll_on[g] |=> (cfg_q.div[g] == $past(cfg_q.div[g])));
    end

endmodule

// File: rtl/refpre_srcsel.sv
module refpre_srcsel
    import refpre_pkg::*;
#(
    parameter int SRCS = NUM_SRC
) (
    input  logic [SRCS-1:0] osc_tick,
    input  src_sel_e        src,
    output logic            tick,
    output logic            live
);

    always_comb begin
        tick = 1'b0;
        live = 1'b0;
        for (int i = 0; i < SRCS; i++) begin
            if (int'(src) == i) begin
                tick = osc_tick[i];
                live = 1'b1;
            end
        end
    end

endmodule

// File: rtl/refpre_div.sv
module refpre_div
    import refpre_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      live,
    input  div_code_t code,
    input  logic      restart,
    output logic      en
);

    div_mode_e mode;
    div_code_t cnt;

    assign mode = decode_div(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
        end else begin
            en <= 1'b0;
            unique case (mode)
                DIV_OFF: cnt <= '0;
                DIV_PASS: begin
                    cnt <= '0;
                    en  <= tick;
                end
                default: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            en  <= 1'b1;
                            cnt <= code - div_code_t'(1);
                        end else begin
                            cnt <= cnt - div_code_t'(1);
                        end
                    end
                end
            endcase
            if (restart || !live)
                cnt <= '0;
        end
    end

    // R4: code 0 gates the output
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == DIV_OFF) |=> !en);

    // R9: no source selected means no pulses
    a_r9_nosrc_quiet: assert property (@(posedge clk) disable iff (rst)
        !live |=> !en);

    // R6: a dividing prescaler never pulses twice in a row
    a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
        (en && mode == DIV_COUNT && !$past(restart)) |=> !en);

endmodule

// File: rtl/refpre_unit.sv
module refpre_unit
    import refpre_pkg::*;
#(
    parameter int SRCS = NUM_SRC,
    localparam int W   = CFG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [W-1:0]       wr_data,
    input  logic [NUM_PLL-1:0] pll_on,
    input  logic [SRCS-1:0]    osc_tick,
    output logic [W-1:0]       rd_data,
    output logic [NUM_PLL-1:0] ref_en
);

    cfg_t               cfg_q;
    logic [NUM_PLL-1:0] restart;
    logic               tick_sel;
    logic               src_live;

    refpre_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_cfg  (cfg_t'(wr_data)),
        .pll_on  (pll_on),
        .cfg_q   (cfg_q),
        .restart (restart)
    );

    refpre_srcsel #(.SRCS(SRCS)) u_sel (
        .osc_tick (osc_tick),
        .src      (cfg_q.src),
        .tick     (tick_sel),
        .live     (src_live)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_div
        refpre_div u_div (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_sel),
            .live    (src_live),
            .code    (cfg_q.div[g]),
            .restart (restart[g]),
            .en      (ref_en[g])
        );
    end

    assign rd_data = W'(cfg_q);

endmodule

// File: tb/refpre_unit_test.sv
module refpre_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_data = '0;
    logic [2:0]  pll_on = '0;
    logic [2:0]  osc_tick = '0;
    logic [19:0] rd_data;
    logic [2:0]  ref_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    refpre_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pll_on(pll_on), .osc_tick(osc_tick), .rd_data(rd_data), .ref_en(ref_en)
    );

    typedef struct packed {
        logic [1:0] src;
        logic [5:0] code;
        logic [7:0] gap;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 6'd2,  8'd2},
        '{2'd1, 6'd5,  8'd5},
        '{2'd2, 6'd63, 8'd63},
        '{2'd0, 6'd1,  8'd1},
        '{2'd0, 6'd0,  8'd0},
        '{2'd3, 6'd7,  8'd0},
        '{2'd2, 6'd32, 8'd32}
    };

    function automatic logic [19:0] mk(input logic [1:0] s, input logic [5:0] d0,
                                       input logic [5:0] d1, input logic [5:0] d2);
        return {d2, d1, d0, s};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called right after wr: checks the pulse after the write edge, then the gap
    task automatic measure(input string tag, input int gap);
        int first [3];
        @(negedge clk);
        chk({tag, " first pulse"}, ref_en, (gap != 0) ? 3'b111 : 3'b000);
        for (int c = 0; c < 3; c++) first[c] = 0;
        for (int n = 1; n <= 70; n++) begin
            @(negedge clk);
            for (int c = 0; c < 3; c++)
                if (first[c] == 0 && ref_en[c]) first[c] = n;
        end
        for (int c = 0; c < 3; c++)
            chk({tag, " gap"}, first[c], gap);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int pulses;
        logic pat [6];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk("R2 reset config", rd_data, mk(2'd0, 6'd32, 6'd32, 6'd0));
        @(negedge clk);
        chk("R2 reset outputs", ref_en, 3'b000);

        // Vector table: R6, R4, R9, R8, R7
        osc_tick = 3'b111;
        foreach (VECS[i]) begin
            wr(mk(VECS[i].src, VECS[i].code, VECS[i].code, VECS[i].code));
            chk("R8 readback", rd_data, mk(VECS[i].src, VECS[i].code, VECS[i].code, VECS[i].code));
            measure("R6 R4 R9 vector", int'(VECS[i].gap));
        end

        // R3 and R5: write protection
        wr(mk(2'd0, 6'd4, 6'd4, 6'd9));
        @(negedge clk);
        pll_on = 3'b100;
        wr(mk(2'd2, 6'd6, 6'd6, 6'd12));
        chk("R3 R5 blocked by pll 2", rd_data, mk(2'd0, 6'd6, 6'd6, 6'd9));
        pll_on = 3'b001;
        wr(mk(2'd1, 6'd10, 6'd11, 6'd13));
        chk("R3 R5 blocked by pll 0", rd_data, mk(2'd0, 6'd6, 6'd11, 6'd13));
        pll_on = 3'b000;

        // R1: source routing with bypass
        wr(mk(2'd1, 6'd1, 6'd1, 6'd1));
        osc_tick = 3'b010;
        @(negedge clk); @(negedge clk);
        chk("R1 src1 follows osc1", ref_en, 3'b111);
        osc_tick = 3'b101;
        @(negedge clk); @(negedge clk);
        chk("R1 src1 ignores osc0 osc2", ref_en, 3'b000);
        wr(mk(2'd2, 6'd1, 6'd1, 6'd1));
        osc_tick = 3'b100;
        @(negedge clk); @(negedge clk);
        chk("R1 src2 follows osc2", ref_en, 3'b111);
        osc_tick = 3'b011;
        @(negedge clk); @(negedge clk);
        chk("R1 src2 ignores osc0 osc1", ref_en, 3'b000);

        // R9: source 3 with all ticks
        wr(mk(2'd3, 6'd1, 6'd1, 6'd1));
        osc_tick = 3'b111;
        @(negedge clk); @(negedge clk);
        chk("R9 no source", ref_en, 3'b000);

        // R4: bypass tracks the tick one cycle later
        wr(mk(2'd0, 6'd1, 6'd1, 6'd1));
        pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        foreach (pat[i]) begin
            osc_tick[0] = pat[i];
            @(negedge clk);
            chk("R4 bypass", ref_en[0], pat[i]);
        end

        // R6: counts selected ticks, not clock cycles
        wr(mk(2'd0, 6'd3, 6'd3, 6'd3));
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            osc_tick[0] = (i % 2 == 0);
            @(negedge clk);
            pulses += int'(ref_en[0]);
        end
        chk("R6 half-rate ticks", pulses, 10);

        // R7: restart mid-period
        osc_tick = 3'b111;
        wr(mk(2'd0, 6'd5, 6'd5, 6'd5));
        @(negedge clk); @(negedge clk);
        wr(mk(2'd0, 6'd7, 6'd7, 6'd7));
        measure("R7 restart", 7);

        report();
    end

endmodule